// File: doc/BRIEF.md
# Single-Bit Static Memory Emulator

This block is a clocked model of a 16,384 x 1 static memory with an asynchronous interface. The host sees a 14-bit address, an active-low select, an active-low write strobe, one data-in bit and one data-out bit. Because the host pins may change at any time, the core samples its inputs on a fast internal clock. It then rebuilds the write window and the read state from those samples.

A write lasts as long as select and write strobe are both low. The bit is stored when the window closes, whichever of the two strobes rises first. The output driver is modelled by a registered enable flag: the flag is low while the part is deselected or a write is open. A power-down flag follows the deselected state. Storage is a 128-row by 128-column array. The low seven address bits pick the row and the high seven pick the column.

Top module: `bitram_emu`

## Requirements
- R1: The memory holds 2^(ROW_BITS+COL_BITS) one-bit words (16,384 by default), each independently stored and read back. Address bits [ROW_BITS-1:0] select the row and the upper bits select the column.
- R2: Data is written only while ce_n_i and we_n_i are both low. Pulsing we_n_i low while ce_n_i is high leaves every location unchanged.
- R3: Each write window commits exactly once, when either strobe rises. It stores din_i at addr_i as sampled in the last internal cycle before the close. This holds whether we_n_i, ce_n_i or both together end the window.
- R4: With ce_n_i low and we_n_i high, dout_o shows the addressed bit and oe_o is 1. Both update LAT = SYNC_STAGES+2 clock edges after the input change, and not one edge earlier.
- R5: oe_o is 0 whenever ce_n_i is high or we_n_i is low, with the same latency of LAT edges.
- R6: When ce_n_i and we_n_i rise in the same cycle to end a write, oe_o stays 0 throughout.
- R7: pd_o is 1 while ce_n_i is high and 0 while it is low, with a latency of LAT edges.
- R8: While oe_o is 0, dout_o keeps its last driven value.
- R9: After synchronous reset, oe_o = 0, pd_o = 1 and dout_o = 0.
- R10: On the first cycle that oe_o returns to 1 after a we_n_i-terminated write, dout_o already shows the newly written bit when the address is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| addr_i | input | ROW_BITS+COL_BITS | Word address |
| ce_n_i | input | 1 | Select, active low |
| we_n_i | input | 1 | Write strobe, active low |
| din_i | input | 1 | Write data bit |
| dout_o | output | 1 | Read data bit |
| oe_o | output | 1 | Output driver enable (0 = high impedance) |
| pd_o | output | 1 | Power-down indication |

## Verification
Every host-visible result (data, driver enable and power-down) is due LAT = 4 clock edges after the input change that causes it. That count covers two synchroniser flops, one state/array register and one output register. The bench drives inputs just after a falling edge and samples on the falling edge after exactly LAT rising edges. A streaming read checks one address per cycle on that fixed offset, and the latency check samples one edge early as well to confirm the old value is still held. The high-impedance, joint-rise and write-forwarding checks sample every cycle across the window, so a single premature or late transition is caught.

// File: rtl/bitram_pkg.sv
package bitram_pkg;
  typedef enum logic [1:0] {
    MODE_DESEL = 2'd0,
    MODE_READ  = 2'd1,
    MODE_WRITE = 2'd2
  } bus_mode_e;
endpackage

// File: rtl/bitram_sync.sv
module bitram_sync #(
  parameter int unsigned      W       = 1,
  parameter int unsigned      STAGES  = 2,
  parameter logic [W-1:0]     RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= RST_VAL;
        else     chain[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= RST_VAL;
        else     chain[s] <= chain[s-1];
      end
    end
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/bitram_ctrl.sv
module bitram_ctrl
  import bitram_pkg::*;
#(
  parameter int unsigned AW = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce_s,
  input  logic          we_s,
  input  logic [AW-1:0] addr_s,
  input  logic          din_s,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic          wr_bit,
  output logic          load_q,
  output logic          oe_q,
  output logic          pd_q
);
  bus_mode_e mode_now;
  logic          win_q;
  logic [AW-1:0] wa_q;
  logic          wd_q;
  logic          pd1_q;

  always_comb begin
    if (ce_s)      mode_now = MODE_DESEL;
    else if (we_s) mode_now = MODE_READ;
    else           mode_now = MODE_WRITE;
  end

  // Window tracking: address and data follow the window, frozen on close.
  always_ff @(posedge clk) begin
    if (rst) begin
      win_q <= 1'b0;
      wa_q  <= '0;
      wd_q  <= 1'b0;
    end else begin
      win_q <= (mode_now == MODE_WRITE);
      if (mode_now == MODE_WRITE) begin
        wa_q <= addr_s;
        wd_q <= din_s;
      end
    end
  end

  assign wr_en   = win_q && (mode_now != MODE_WRITE);
  assign wr_addr = wa_q;
  assign wr_bit  = wd_q;

  // Two-stage status pipeline, aligned with the array read path.
  always_ff @(posedge clk) begin
    if (rst) begin
      load_q <= 1'b0;
      pd1_q  <= 1'b1;
      oe_q   <= 1'b0;
      pd_q   <= 1'b1;
    end else begin
      load_q <= (mode_now == MODE_READ);
      pd1_q  <= (mode_now == MODE_DESEL);
      oe_q   <= load_q;
      pd_q   <= pd1_q;
    end
  end

  a_r3_one_commit: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en);

  a_r5_quiet_in_write: assert property (@(posedge clk) disable iff (rst)
    (mode_now == MODE_WRITE) |-> ##2 !oe_q);

  a_r6_joint_rise: assert property (@(posedge clk) disable iff (rst)
    (win_q && mode_now == MODE_DESEL) |-> ##2 !oe_q);
endmodule

// File: rtl/bitram_array.sv
module bitram_array #(
  parameter int unsigned ROW_BITS = 7,
  parameter int unsigned COL_BITS = 7
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic [ROW_BITS+COL_BITS-1:0] wr_addr,
  input  logic                         wr_bit,
  input  logic [ROW_BITS+COL_BITS-1:0] rd_addr,
  output logic                         rd_bit
);
  localparam int unsigned AW   = ROW_BITS + COL_BITS;
  localparam int unsigned ROWS = 1 << ROW_BITS;
  localparam int unsigned COLS = 1 << COL_BITS;

  logic [COLS-1:0]     mem [ROWS];
  logic [COLS-1:0]     row_q;
  logic [COL_BITS-1:0] col_q;
  logic                fwd_q;
  logic                fwd_bit_q;

  wire [ROW_BITS-1:0] wr_row = wr_addr[ROW_BITS-1:0];
  wire [COL_BITS-1:0] wr_col = wr_addr[AW-1:ROW_BITS];
  wire [ROW_BITS-1:0] rd_row = rd_addr[ROW_BITS-1:0];
  wire [COL_BITS-1:0] rd_col = rd_addr[AW-1:ROW_BITS];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_row][wr_col] <= wr_bit;
    row_q <= mem[rd_row];
    col_q <= rd_col;
  end

  // Same-cycle write/read to one word: hand the new bit straight through.
  always_ff @(posedge clk) begin
    if (rst) begin
      fwd_q     <= 1'b0;
      fwd_bit_q <= 1'b0;
    end else begin
      fwd_q     <= wr_en && (wr_addr == rd_addr);
      fwd_bit_q <= wr_bit;
    end
  end

  assign rd_bit = fwd_q ? fwd_bit_q : row_q[col_q];

  a_r10_write_through: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_addr == rd_addr)) |=> (rd_bit == $past(wr_bit)));
endmodule

// File: rtl/bitram_emu.sv
module bitram_emu #(
  parameter int unsigned ROW_BITS    = 7,
  parameter int unsigned COL_BITS    = 7,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [ROW_BITS+COL_BITS-1:0] addr_i,
  input  logic                         ce_n_i,
  input  logic                         we_n_i,
  input  logic                         din_i,
  output logic                         dout_o,
  output logic                         oe_o,
  output logic                         pd_o
);
  localparam int unsigned AW = ROW_BITS + COL_BITS;

  logic [1:0]    ctl_s;
  logic [AW:0]   dat_s;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic          wr_bit;
  logic          load_q;
  logic          rd_bit;

  bitram_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_ctl_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({ce_n_i, we_n_i}),
    .q_o (ctl_s)
  );

  bitram_sync #(.W(AW+1), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_dat_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({din_i, addr_i}),
    .q_o (dat_s)
  );

  bitram_ctrl #(.AW(AW)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .ce_s    (ctl_s[1]),
    .we_s    (ctl_s[0]),
    .addr_s  (dat_s[AW-1:0]),
    .din_s   (dat_s[AW]),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_bit  (wr_bit),
    .load_q  (load_q),
    .oe_q    (oe_o),
    .pd_q    (pd_o)
  );

  bitram_array #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)) u_array (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_bit  (wr_bit),
    .rd_addr (dat_s[AW-1:0]),
    .rd_bit  (rd_bit)
  );

  always_ff @(posedge clk) begin
    if (rst)         dout_o <= 1'b0;
    else if (load_q) dout_o <= rd_bit;
  end

  a_r8_hold_when_off: assert property (@(posedge clk) disable iff (rst)
    !oe_o |-> $stable(dout_o));

  a_r5_no_drive_in_powerdown: assert property (@(posedge clk) disable iff (rst)
    oe_o |-> !pd_o);
endmodule

// File: tb/bitram_emu_test.sv
module bitram_emu_test;
  localparam int CLK_PERIOD = 10;
  localparam int ROW_BITS = 7;
  localparam int COL_BITS = 7;
  localparam int SYNC = 2;
  localparam int AW = ROW_BITS + COL_BITS;
  localparam int N = 1 << AW;
  localparam int LAT = SYNC + 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic ce_n = 1'b1;
  logic we_n = 1'b1;
  logic din = 1'b0;
  logic dout, oe, pd;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bitram_emu #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS), .SYNC_STAGES(SYNC)) uut (
    .clk(clk), .rst(rst), .addr_i(addr), .ce_n_i(ce_n), .we_n_i(we_n),
    .din_i(din), .dout_o(dout), .oe_o(oe), .pd_o(pd)
  );

  function automatic logic pat(input int a);
    logic [AW-1:0] v;
    v = AW'(a);
    return (^(v & 14'h1B2D)) ^ v[ROW_BITS];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic go_idle();
    @(negedge clk); ce_n = 1'b1; we_n = 1'b1;
    repeat (LAT + 1) @(negedge clk);
  endtask

  task automatic rd(input int a, output logic v, output logic o);
    @(negedge clk); addr = AW'(a); ce_n = 1'b0; we_n = 1'b1;
    repeat (LAT) @(posedge clk);
    @(negedge clk); v = dout; o = oe;
  endtask

  task automatic wr_we(input int a, input logic d);
    @(negedge clk); addr = AW'(a); din = d; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk); we_n = 1'b1;
    repeat (LAT) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    logic v, o;
    bit seen_off, seen_on;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk("R9 oe", oe, 0); chk("R9 pd", pd, 1); chk("R9 dout", dout, 0);
    // R7 deselected
    chk("R7 pd idle", pd, 1);

    // R1 exhaustive write sweep (WE-terminated writes)
    for (int a = 0; a < N; a++) begin
      @(negedge clk); addr = AW'(a); din = pat(a); ce_n = 1'b0; we_n = 1'b0;
      @(negedge clk); we_n = 1'b1;
    end
    // R1 / R4 streaming read, one address per cycle, due LAT edges later
    for (int i = 0; i < N + LAT; i++) begin
      @(negedge clk);
      if (i >= LAT) begin
        chk("R1 data", dout, pat(i - LAT));
        if (oe !== 1'b1) chk("R4 oe", oe, 1);
      end
      if (i < N) addr = AW'(i);
    end
    chk("R7 pd selected", pd, 0);

    // R4 exact latency
    wr_we(100, 1'b0); wr_we(101, 1'b1);
    rd(100, v, o);
    chk("R4 read 0", v, 0); chk("R4 oe", o, 1);
    @(negedge clk); addr = AW'(101);
    repeat (LAT - 1) @(negedge clk);
    chk("R4 not early", dout, 0);
    @(negedge clk);
    chk("R4 on time", dout, 1);

    // R2 strobe while deselected is ignored
    go_idle();
    @(negedge clk); addr = AW'(100); din = 1'b1; we_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R7 pd during ignored strobe", pd, 1);
    chk("R5 oe during ignored strobe", oe, 0);
    we_n = 1'b1;
    go_idle();
    rd(100, v, o); chk("R2 unchanged", v, 0);

    // R3 CE-terminated, address moved inside window: last sample wins
    wr_we(200, 1'b0); wr_we(300, 1'b0);
    go_idle();
    @(negedge clk); we_n = 1'b0; addr = AW'(200); din = 1'b1;
    @(negedge clk); ce_n = 1'b0;
    repeat (2) @(negedge clk);
    addr = AW'(300); din = 1'b1;
    repeat (LAT + 1) @(negedge clk);
    // R5 long write window
    chk("R5 oe in window", oe, 0); chk("R7 pd in window", pd, 0);
    ce_n = 1'b1;
    repeat (2) @(negedge clk);
    we_n = 1'b1;
    go_idle();
    rd(300, v, o); chk("R3 ce-ended data", v, 1);
    rd(200, v, o); chk("R3 earlier addr untouched", v, 0);

    // R6 joint rise keeps the driver off; R3 commit on joint close
    wr_we(400, 1'b0);
    go_idle();
    @(negedge clk); addr = AW'(400); din = 1'b1; ce_n = 1'b0; we_n = 1'b0;
    repeat (2) @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
    for (int k = 0; k < LAT + 4; k++) begin
      @(negedge clk);
      chk("R6 oe stays off", oe, 0);
    end
    rd(400, v, o); chk("R3 joint-close data", v, 1);

    // R10 first driven cycle after a write shows the new bit
    wr_we(500, 1'b0);
    rd(500, v, o); chk("R10 before", v, 0);
    @(negedge clk); din = 1'b1; we_n = 1'b0;
    @(negedge clk); we_n = 1'b1;
    seen_off = 0; seen_on = 0;
    for (int k = 0; k < 3 * LAT; k++) begin
      @(negedge clk);
      if (!oe) seen_off = 1;
      else if (seen_off && !seen_on) begin
        seen_on = 1;
        chk("R10 first driven bit", dout, 1);
      end
    end
    chk("R10 driver returned", seen_on, 1);

    // R8 hold while driver off
    rd(101, v, o); chk("R8 setup", v, 1);
    @(negedge clk); ce_n = 1'b1; addr = AW'(100);
    repeat (LAT + 2) @(negedge clk);
    chk("R8 oe off", oe, 0); chk("R8 dout held", dout, 1);
    chk("R7 pd back", pd, 1);

    done = 1;
    report();
  end
endmodule